// File: doc/BRIEF.md
# Prioritized Multi-Level Interrupt Controller

This block gathers twenty-four interrupt request lines, arranged as three banks of eight. A rising edge on a request line, or a 1 written to the matching bit of a bank's set register, makes that source pending. Each source also has two enable bits, one in the bank's enable-high register and one in its enable-low register. Together these two bits form a two-bit level code, and the code 00 keeps the source silent.

When the global enable is on and no interrupt is in service, the controller picks the pending source with the highest level. It presents a registered request and a vector address to the CPU, and holds both until the CPU acknowledges. The acknowledge clears the source's pending bit, records the source number, and puts the controller in service. In that state no further request is offered until the CPU signals a return from interrupt. While the global enable is off, the pending bits keep latching, so software can poll them.

Top module: `irqc_top`

## Requirements
- R1: A rising edge on `irq_in[s]` sets the pending bit of source s one clock later. Pending for source 8*b+i reads as bit i at register address 4*b+0.
- R2: Writing data d to address 4*b+1 sets the pending bit of source 8*b+i for every i where d[i]=1. Writes never clear a pending bit.
- R3: Source 8*b+i takes its level from {bit i of address 4*b+2, bit i of address 4*b+3}, the high bit first. Level 00 is never offered, even while pending.
- R4: When more than one enabled source is pending, the controller offers the one with the highest level (11 > 10 > 01).
- R5: Among pending sources at the same level, the controller offers the lowest source number.
- R6: The vector offered for source s is 0x0004 + 4*s.
- R7: While the global enable is off (`gie_off` pulse; reset state), no request is offered and pending bits still latch. `gie_on` and `gie_off` do not change any enable register.
- R8: An acknowledge while a request is offered clears that source's pending bit and loads `last_src` with it. A request edge on the same source in the same cycle leaves the bit set.
- R9: After an acknowledge, no request is offered until `irq_ret` is pulsed. A higher-level source arriving in that time does not preempt the one in service.
- R10: `irq_req` rises one clock after the pending bit becomes visible. While the request waits for an acknowledge, `irq_req` and `irq_vector` stay stable.
- R11: After reset, all registers read 0, the global enable is off, `irq_req` is 0 and `last_src` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 24 | Request lines; the rising edge is captured |
| gie_on | input | 1 | Pulse that turns the global enable on |
| gie_off | input | 1 | Pulse that turns the global enable off (wins over gie_on) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | {bank, kind}: kind 0 pending, 1 set, 2 enable-high, 3 enable-low |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr (set register reads 0) |
| irq_ack | input | 1 | CPU acknowledge of the offered request |
| irq_ret | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Registered interrupt request to the CPU |
| irq_vector | output | 16 | Registered vector address of the offered source |
| last_src | output | 5 | Number of the source most recently acknowledged |

## Verification
Each result has a fixed latency:
- A request edge or a set write shows in the pending read one clock later.
- `irq_req` and the vector follow one clock after that.
- `last_src` and the cleared pending bit show one clock after the acknowledge.
- A new offer can appear one clock after the return pulse.

The bench drives inputs on falling edges and samples at the next falling edge, or the one after, according to that count. In particular, it checks that the request is still low one cycle after a set write, and that it is high one cycle later. A scoreboard queue holds the source numbers the requirements predict, in order. The monitor checks each request's vector and the following `last_src` against the head of that queue.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        LVL_OFF  = 2'b00,
        LVL_LOW  = 2'b01,
        LVL_NOM  = 2'b10,
        LVL_HIGH = 2'b11
    } level_e;

    typedef enum logic [1:0] {
        REG_PEND = 2'b00,
        REG_SET  = 2'b01,
        REG_ENH  = 2'b10,
        REG_ENL  = 2'b11
    } regsel_e;

    typedef enum logic [1:0] {
        DSP_IDLE  = 2'b00,
        DSP_OFFER = 2'b01,
        DSP_BUSY  = 2'b10
    } dsp_e;

    typedef struct packed {
        logic   found;
        level_e lvl;
    } pick_info_t;

    function automatic int unsigned vec_addr(int unsigned base, int unsigned step,
                                             int unsigned idx);
        return base + step * idx;
    endfunction

endpackage

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] req_in,
    input  logic              we,
    input  regsel_e           kind,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] ack_clr,
    output logic [BANK_W-1:0] pend,
    output logic [BANK_W-1:0] en_hi,
    output logic [BANK_W-1:0] en_lo
);
    logic [BANK_W-1:0] req_q;
    logic [BANK_W-1:0] rise;
    logic [BANK_W-1:0] swset;

    assign rise  = req_in & ~req_q;
    assign swset = (we && kind == REG_SET) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            pend  <= '0;
            en_hi <= '0;
            en_lo <= '0;
        end else begin
            req_q <= req_in;
            pend  <= (pend & ~ack_clr) | rise | swset;
            if (we && kind == REG_ENH) en_hi <= wdata;
            if (we && kind == REG_ENL) en_lo <= wdata;
        end
    end

    // R2: a software set makes every addressed bit pending
    assert_swset_R2: assert property (@(posedge clk) disable iff (rst)
        (we && kind == REG_SET) |=> ((pend & $past(wdata)) == $past(wdata)));

    // R1: an input edge is captured
    assert_edge_R1: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((pend & $past(rise)) == $past(rise)));

    // R8: an acknowledged bit drops unless re-requested in the same cycle
    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (|ack_clr) |=> ((pend & $past(ack_clr & ~rise & ~swset)) == '0));

endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 24,
    parameter int SRC_W   = 5
) (
    input  logic [NUM_SRC-1:0]      pend,
    input  logic [NUM_SRC-1:0][1:0] lvl,
    output pick_info_t              info,
    output logic [SRC_W-1:0]        src
);
    always_comb begin
        info.found = 1'b0;
        info.lvl   = LVL_OFF;
        src        = '0;
        // walk downward so that ties resolve to the lowest index
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i] && lvl[i] != 2'b00 && lvl[i] >= info.lvl) begin
                info.found = 1'b1;
                info.lvl   = level_e'(lvl[i]);
                src        = SRC_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqc_dispatch.sv
module irqc_dispatch
    import irqc_pkg::*;
#(
    parameter int NUM_SRC  = 24,
    parameter int SRC_W    = 5,
    parameter int VEC_W    = 16,
    parameter int VEC_BASE = 4,
    parameter int VEC_STEP = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               gie,
    input  pick_info_t         info,
    input  logic [SRC_W-1:0]   pick_src,
    input  logic               ack,
    input  logic               ret,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vector,
    output logic [SRC_W-1:0]   cur_src,
    output logic [SRC_W-1:0]   last_src,
    output logic [NUM_SRC-1:0] clr
);
    dsp_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= DSP_IDLE;
            irq_req    <= 1'b0;
            irq_vector <= '0;
            cur_src    <= '0;
            last_src   <= '0;
        end else begin
            unique case (st)
                DSP_IDLE: if (gie && info.found) begin
                    st         <= DSP_OFFER;
                    irq_req    <= 1'b1;
                    cur_src    <= pick_src;
                    irq_vector <= VEC_W'(vec_addr(VEC_BASE, VEC_STEP, int'(pick_src)));
                end
                DSP_OFFER: if (ack) begin
                    st       <= DSP_BUSY;
                    irq_req  <= 1'b0;
                    last_src <= cur_src;
                end else if (!gie) begin
                    st      <= DSP_IDLE;
                    irq_req <= 1'b0;
                end
                DSP_BUSY: if (ret) st <= DSP_IDLE;
                default: st <= DSP_IDLE;
            endcase
        end
    end

    always_comb begin
        clr = '0;
        if (st == DSP_OFFER && ack) clr[cur_src] = 1'b1;
    end

    // R10: an unanswered request holds its vector
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !ack && gie) |=> (irq_req && $stable(irq_vector)));

    // R9: no offer while an interrupt is in service
    assert_no_nest_R9: assert property (@(posedge clk) disable iff (rst)
        (st == DSP_BUSY && !ret) |=> !irq_req);

    // R7: global enable off withdraws or suppresses the request
    assert_gie_R7: assert property (@(posedge clk) disable iff (rst)
        !gie |=> !irq_req);

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 8,
    parameter int VEC_W     = 16,
    parameter int VEC_BASE  = 4,
    parameter int VEC_STEP  = 4,
    localparam int NUM_SRC  = NUM_BANKS * BANK_W,
    localparam int SRC_W    = $clog2(NUM_SRC),
    localparam int BSEL_W   = $clog2(NUM_BANKS),
    localparam int ADDR_W   = BSEL_W + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               gie_on,
    input  logic               gie_off,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [BANK_W-1:0]  reg_wdata,
    output logic [BANK_W-1:0]  reg_rdata,
    input  logic               irq_ack,
    input  logic               irq_ret,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vector,
    output logic [SRC_W-1:0]   last_src
);
    logic [NUM_SRC-1:0]      pend, en_hi, en_lo, clr;
    logic [NUM_SRC-1:0][1:0] lvl;
    logic [BSEL_W-1:0]       bsel;
    regsel_e                 kind;
    logic                    gie;
    pick_info_t              info;
    logic [SRC_W-1:0]        pick_src, cur_src;

    assign bsel = reg_addr[ADDR_W-1:2];
    assign kind = regsel_e'(reg_addr[1:0]);

    always_ff @(posedge clk) begin
        if (rst)          gie <= 1'b0;
        else if (gie_off) gie <= 1'b0;
        else if (gie_on)  gie <= 1'b1;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = reg_we && (bsel == BSEL_W'(b));
        irqc_bank #(.BANK_W(BANK_W)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .req_in  (irq_in[b*BANK_W +: BANK_W]),
            .we      (hit),
            .kind    (kind),
            .wdata   (reg_wdata),
            .ack_clr (clr[b*BANK_W +: BANK_W]),
            .pend    (pend[b*BANK_W +: BANK_W]),
            .en_hi   (en_hi[b*BANK_W +: BANK_W]),
            .en_lo   (en_lo[b*BANK_W +: BANK_W])
        );
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_lvl
        assign lvl[s] = {en_hi[s], en_lo[s]};
    end

    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bsel == BSEL_W'(b)) begin
                unique case (kind)
                    REG_PEND: reg_rdata = pend[b*BANK_W +: BANK_W];
                    REG_ENH:  reg_rdata = en_hi[b*BANK_W +: BANK_W];
                    REG_ENL:  reg_rdata = en_lo[b*BANK_W +: BANK_W];
                    default:  reg_rdata = '0;
                endcase
            end
        end
    end

    irqc_pick #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_pick (
        .pend (pend),
        .lvl  (lvl),
        .info (info),
        .src  (pick_src)
    );

    irqc_dispatch #(
        .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .VEC_W(VEC_W),
        .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
    ) u_dispatch (
        .clk        (clk),
        .rst        (rst),
        .gie        (gie),
        .info       (info),
        .pick_src   (pick_src),
        .ack        (irq_ack),
        .ret        (irq_ret),
        .irq_req    (irq_req),
        .irq_vector (irq_vector),
        .cur_src    (cur_src),
        .last_src   (last_src),
        .clr        (clr)
    );

    // R1: the offered source is still pending until acknowledged
    assert_offer_live_R1: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> pend[cur_src]);

    // R6: vector and source agree
    assert_vector_R6: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vector == VEC_W'(vec_addr(VEC_BASE, VEC_STEP, int'(cur_src)))));

endmodule

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] irq_in = '0;
    logic        gie_on = 1'b0, gie_off = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq_ack, irq_ret, irq_req;
    logic [15:0] irq_vector;
    logic [4:0]  last_src;

    logic mon_ack = 1'b0, mon_ret = 1'b0, man_ack = 1'b0, man_ret = 1'b0;
    logic auto_mode = 1'b0, busy = 1'b0;
    int   checks = 0, errors = 0;
    int   expq[$];

    assign irq_ack = mon_ack | man_ack;
    assign irq_ret = mon_ret | man_ret;

    always #10 clk = ~clk;

    irqc_top dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .gie_on(gie_on), .gie_off(gie_off),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req),
        .irq_vector(irq_vector), .last_src(last_src)
    );

    function automatic logic [15:0] vec_of(int s);
        return 16'(4 + 4 * s);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, tag, int'(reg_rdata), int'(exp));
    endtask

    task automatic pulse_in(input int s);
        @(negedge clk); irq_in[s] = 1'b1;
        @(negedge clk); irq_in[s] = 1'b0;
    endtask

    task automatic gie_cmd(input bit on);
        @(negedge clk);
        if (on) gie_on = 1'b1; else gie_off = 1'b1;
        @(negedge clk);
        gie_on = 1'b0; gie_off = 1'b0;
    endtask

    task automatic drain();
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (expq.size() == 0 && !busy) break;
        end
        repeat (3) @(negedge clk);
        chk(expq.size() == 0, "R4 scoreboard drained", expq.size(), 0);
    endtask

    // monitor: serve each request, compare against the scoreboard head
    initial forever begin
        @(negedge clk);
        if (auto_mode && irq_req) begin
            int exp;
            busy = 1'b1;
            if (expq.size() == 0) begin
                exp = -1;
                chk(1'b0, "R4 unexpected request", int'(irq_vector), 0);
            end else begin
                exp = expq.pop_front();
                chk(irq_vector == vec_of(exp), "R6 vector of offered source",
                    int'(irq_vector), int'(vec_of(exp)));
            end
            mon_ack = 1'b1;
            @(negedge clk);
            mon_ack = 1'b0;
            if (exp >= 0)
                chk(last_src == 5'(exp), "R8 last_src after ack", int'(last_src), exp);
            mon_ret = 1'b1;
            @(negedge clk);
            mon_ret = 1'b0;
            busy = 1'b0;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(irq_req == 1'b0, "R11 irq_req after reset", int'(irq_req), 0);
        chk(last_src == 5'd0, "R11 last_src after reset", int'(last_src), 0);
        for (int a = 0; a < 12; a++) rd_chk(4'(a), 8'h00, "R11 register after reset");

        // R1 edge capture, R7 latching while globally disabled
        pulse_in(3);
        rd_chk(4'h0, 8'h08, "R1 pending after edge on source 3");
        // R2 software set of source 8
        wr(4'h5, 8'h01);
        rd_chk(4'h4, 8'h01, "R2 pending after set write");
        // levels: source 3 = 01, source 8 = 11
        wr(4'h3, 8'h08);
        wr(4'h6, 8'h01);
        wr(4'h7, 8'h01);
        repeat (3) @(negedge clk);
        chk(irq_req == 1'b0, "R7 no request while globally off", int'(irq_req), 0);

        // R4 higher level first
        expq.push_back(8);
        expq.push_back(3);
        auto_mode = 1'b1;
        gie_cmd(1'b1);
        drain();
        rd_chk(4'h6, 8'h01, "R7 enable-high unchanged by global enable");
        rd_chk(4'h7, 8'h01, "R7 enable-low unchanged by global enable");
        rd_chk(4'h0, 8'h00, "R8 pending cleared after service");

        // R5 equal level: sources 2 and 5 at level 10, set together
        wr(4'h2, 8'h24);
        expq.push_back(2);
        expq.push_back(5);
        wr(4'h1, 8'h24);
        drain();

        // R3 level 00 is never offered
        wr(4'h9, 8'h10);
        repeat (6) @(negedge clk);
        chk(irq_req == 1'b0, "R3 disabled source not offered", int'(irq_req), 0);
        rd_chk(4'h8, 8'h10, "R3 disabled source still pending");

        // manual handshake: R10 timing, R8 same-cycle re-set, R9 no preemption
        auto_mode = 1'b0;
        wr(4'h3, 8'h0B);          // low bits: sources 0,1,3
        wr(4'h2, 8'h26);          // high bits: sources 1,2,5 -> src0=01, src1=11
        wr(4'h1, 8'h01);          // set source 0
        chk(irq_req == 1'b0, "R10 request not yet up one cycle after set", int'(irq_req), 0);
        @(negedge clk);
        chk(irq_req == 1'b1, "R10 request up", int'(irq_req), 1);
        chk(irq_vector == vec_of(0), "R6 vector of source 0", int'(irq_vector), int'(vec_of(0)));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(irq_req == 1'b1 && irq_vector == vec_of(0), "R10 request held without ack",
                int'(irq_vector), int'(vec_of(0)));
        end
        man_ack = 1'b1; irq_in[0] = 1'b1;
        @(negedge clk);
        man_ack = 1'b0; irq_in[0] = 1'b0;
        chk(last_src == 5'd0, "R8 last_src is source 0", int'(last_src), 0);
        chk(irq_req == 1'b0, "R8 request drops on ack", int'(irq_req), 0);
        rd_chk(4'h0, 8'h01, "R8 same-cycle edge keeps pending");
        wr(4'h1, 8'h02);          // source 1 at level 11 during service
        repeat (4) @(negedge clk);
        chk(irq_req == 1'b0, "R9 no preemption while in service", int'(irq_req), 0);
        man_ret = 1'b1;
        @(negedge clk);
        man_ret = 1'b0;
        chk(irq_req == 1'b0, "R9 request one cycle after return", int'(irq_req), 0);
        @(negedge clk);
        chk(irq_req == 1'b1 && irq_vector == vec_of(1), "R4 level 11 wins after return",
            int'(irq_vector), int'(vec_of(1)));
        expq.push_back(1);
        expq.push_back(0);
        auto_mode = 1'b1;
        drain();
        rd_chk(4'h0, 8'h00, "R8 bank 0 drained");

        // R7 global disable: pending latches, nothing offered
        gie_cmd(1'b0);
        pulse_in(1);
        repeat (4) @(negedge clk);
        chk(irq_req == 1'b0, "R7 no request after global off", int'(irq_req), 0);
        rd_chk(4'h0, 8'h02, "R7 pending latches while off");
        expq.push_back(1);
        gie_cmd(1'b1);
        drain();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule